// File: doc/BRIEF.md
# Sliding-Window Cluster Finder and Object Counter

This block takes a complete grid of tower energies, eta by phi, in a single clock. It moves a 2-by-2 window across every position in the grid and adds up the towers under each window. Neighbouring windows overlap, so each tower is part of up to four sums. A window is a candidate object only if it is a local maximum among its neighbours. Each candidate is compared with four programmable thresholds. For every threshold the block produces a saturating count of the candidates that exceed it. It also produces the total energy of the frame.

Result records for accepted frames go into a small first-in first-out queue. Each record holds the window position and the window sum. A downstream merger reads the counts and the total from a registered result with a valid strobe. It pops the records separately. A new frame can arrive on every clock.

Top module: `swin_cluster_counter`

## Requirements
- R1: `out_valid` pulses high for one cycle, three rising edges after the edge that captures a frame with `in_valid` high. The capture edge counts as the first of the three. Frames on consecutive cycles give results on consecutive cycles.
- R2: Tower (e,p) is `in_grid[(e*8+p)*10 +: 10]`. Window (e,p), for e and p from 0 to 6, adds up towers (e,p), (e+1,p), (e,p+1) and (e+1,p+1). The window is a local maximum when three conditions all hold. Its sum is strictly greater than the sums at (e-1,p) and (e,p-1). Its sum is greater than or equal to the sums at (e+1,p) and (e,p+1). A neighbour outside the window range counts as zero.
- R3: `out_count[3t+2:3t]` counts the local maxima whose sum is strictly greater than threshold t, which is `in_thr[12t+11:12t]`. The count saturates at 7. A window adds to every threshold that it exceeds.
- R4: `out_total` is the sum of all 64 tower energies, with 16 bits of range.
- R5: A frame adds records to the queue only if `in_accept` was high when that frame was captured. There is one record for each local maximum that exceeds at least one threshold. The record layout is eta index in `roi_data[17:15]`, phi index in `[14:12]` and sum in `[11:0]`. Within a frame, records are queued in ascending eta order and then in ascending phi order.
- R6: The queue holds up to 16 records in arrival order. While `roi_empty` is low, `roi_data` shows the oldest record. When `roi_pop` is high and the queue is not empty, the oldest record is removed at the next edge.
- R7: A frame may bring more records than there is free space. Free space is measured before any pop in that same cycle. In that case the earliest records are stored up to capacity and the rest are dropped. `roi_ovf` is then set and stays set until reset.
- R8: After reset, `out_valid` is low, all counts and `out_total` are zero, `roi_empty` is high and `roi_ovf` is low.
- R9: `roi_pop` while the queue is empty has no effect. Later records still come out in order, starting from the first one written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a frame on `in_grid` |
| in_grid | input | 640 | 64 tower energies of 10 bits each |
| in_thr | input | 48 | Four 12-bit thresholds, captured with the frame |
| in_accept | input | 1 | Frame may add records to the queue |
| out_valid | output | 1 | Result strobe |
| out_count | output | 12 | Four 3-bit saturating object counts |
| out_total | output | 16 | Frame energy total |
| roi_pop | input | 1 | Remove the oldest record |
| roi_empty | output | 1 | Queue holds no record |
| roi_data | output | 18 | Oldest record: eta, phi, sum |
| roi_ovf | output | 1 | Sticky flag: a record was dropped |

## Verification
The bench tests tie-breaking on a single hot tower and on a flat plateau. A design with the wrong mix of strict and non-strict comparisons would report up to four objects, or none, where exactly one is expected. Thresholds are set equal to a window sum and one below it, which catches an inclusive comparison. A frame with nine peaks catches counters that wrap instead of saturating. A frame that is not accepted must leave the queue untouched. Two accepted nine-peak frames must fill the queue to sixteen in order, drop the rest and latch the flag. Pops on an empty queue and frames on consecutive cycles show any pointer drift or pipeline mixing through wrong records or wrong counts.

// File: rtl/swin_cluster_counter.sv
module swin_cluster_counter #(
  parameter int ETA = 8,
  parameter int PHI = 8,
  parameter int EW  = 10,
  parameter int NTH = 4,
  parameter int CW  = 3,
  parameter int FD  = 16
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        in_valid,
  input  logic [ETA*PHI*EW-1:0]                       in_grid,
  input  logic [NTH*(EW+2)-1:0]                       in_thr,
  input  logic                                        in_accept,
  output logic                                        out_valid,
  output logic [NTH*CW-1:0]                           out_count,
  output logic [EW+$clog2(ETA*PHI)-1:0]               out_total,
  input  logic                                        roi_pop,
  output logic                                        roi_empty,
  output logic [$clog2(ETA)+$clog2(PHI)+EW+1:0]       roi_data,
  output logic                                        roi_ovf
);
  localparam int NE  = ETA - 1;
  localparam int NP  = PHI - 1;
  localparam int NW  = NE * NP;
  localparam int SW  = EW + 2;
  localparam int TW  = EW + $clog2(ETA*PHI);
  localparam int EIW = $clog2(ETA);
  localparam int PIW = $clog2(PHI);
  localparam int RW  = EIW + PIW + SW;
  localparam int AW  = $clog2(FD);
  localparam int KW  = $clog2(NW + 1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [AW:0]   FDV  = (AW+1)'(FD);

  // stage 1: window sums and total
  logic [SW-1:0]     win_c [NW];
  logic [TW-1:0]     tot_c;
  logic [SW-1:0]     s1_sum [NW];
  logic [TW-1:0]     s1_tot;
  logic [NTH*SW-1:0] s1_thr;
  logic              s1_v, s1_acc;

  always_comb begin
    tot_c = '0;
    for (int k = 0; k < ETA*PHI; k++) tot_c = tot_c + TW'(in_grid[k*EW +: EW]);
  end

  for (genvar e = 0; e < NE; e++) begin : g_we
    for (genvar p = 0; p < NP; p++) begin : g_wp
      assign win_c[e*NP+p] = SW'(in_grid[(e*PHI+p)*EW +: EW])
                           + SW'(in_grid[((e+1)*PHI+p)*EW +: EW])
                           + SW'(in_grid[(e*PHI+p+1)*EW +: EW])
                           + SW'(in_grid[((e+1)*PHI+p+1)*EW +: EW]);
    end
  end

  // stage 2: local maximum and threshold compare
  logic [SW-1:0]  nb_l [NW];
  logic [SW-1:0]  nb_r [NW];
  logic [SW-1:0]  nb_b [NW];
  logic [SW-1:0]  nb_a [NW];
  logic [NW-1:0]  pk_c;
  logic [NTH-1:0] ex_c  [NW];
  logic [NTH-1:0] s2_ex [NW];
  logic [SW-1:0]  s2_sum [NW];
  logic [TW-1:0]  s2_tot;
  logic           s2_v, s2_acc;

  for (genvar e = 0; e < NE; e++) begin : g_ne
    for (genvar p = 0; p < NP; p++) begin : g_np
      localparam int I = e*NP + p;
      if (e > 0)      begin : g_l  assign nb_l[I] = s1_sum[I-NP]; end
      else            begin : g_l0 assign nb_l[I] = '0;           end
      if (e < NE - 1) begin : g_r  assign nb_r[I] = s1_sum[I+NP]; end
      else            begin : g_r0 assign nb_r[I] = '0;           end
      if (p > 0)      begin : g_b  assign nb_b[I] = s1_sum[I-1];  end
      else            begin : g_b0 assign nb_b[I] = '0;           end
      if (p < NP - 1) begin : g_a  assign nb_a[I] = s1_sum[I+1];  end
      else            begin : g_a0 assign nb_a[I] = '0;           end
      assign pk_c[I] = (s1_sum[I] >  nb_l[I]) && (s1_sum[I] >  nb_b[I]) &&
                       (s1_sum[I] >= nb_r[I]) && (s1_sum[I] >= nb_a[I]);
    end
  end

  always_comb begin
    for (int i = 0; i < NW; i++)
      for (int t = 0; t < NTH; t++)
        ex_c[i][t] = pk_c[i] && (s1_sum[i] > s1_thr[t*SW +: SW]);
  end

  // stage 3: counting and record selection
  logic [NW-1:0]     cand;
  logic [KW-1:0]     off [NW];
  logic [KW-1:0]     ncand;
  logic [KW-1:0]     cnt_n;
  logic [NTH*CW-1:0] cnt_c;
  logic [RW-1:0]     rec [NW];

  always_comb begin
    ncand = '0;
    for (int i = 0; i < NW; i++) begin
      cand[i] = |s2_ex[i];
      off[i]  = ncand;
      ncand   = ncand + KW'(cand[i]);
    end
  end

  always_comb begin
    cnt_n = '0;
    cnt_c = '0;
    for (int t = 0; t < NTH; t++) begin
      cnt_n = '0;
      for (int i = 0; i < NW; i++) cnt_n = cnt_n + KW'(s2_ex[i][t]);
      cnt_c[t*CW +: CW] = (cnt_n > KW'(CMAX)) ? CMAX : cnt_n[CW-1:0];
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_re
    for (genvar p = 0; p < NP; p++) begin : g_rp
      assign rec[e*NP+p] = {EIW'(e), PIW'(p), s2_sum[e*NP+p]};
    end
  end

  // pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
      out_count <= '0;
      out_total <= '0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (s2_v) begin
        out_count <= cnt_c;
        out_total <= s2_tot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sum <= win_c;
      s1_tot <= tot_c;
      s1_thr <= in_thr;
      s1_acc <= in_accept;
    end
    if (s1_v) begin
      s2_ex  <= ex_c;
      s2_sum <= s1_sum;
      s2_tot <= s1_tot;
      s2_acc <= s1_acc;
    end
  end

  // record queue
  logic [RW-1:0] mem [FD];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   occ, free, nwr;
  logic          wen, pop_ok, drop;

  assign wen       = s2_v && s2_acc;
  assign free      = FDV - occ;
  assign drop      = wen && (int'(ncand) > int'(free));
  assign nwr       = !wen ? '0 : (drop ? free : (AW+1)'(ncand));
  assign pop_ok    = roi_pop && (occ != '0);
  assign roi_empty = (occ == '0);
  assign roi_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      occ     <= '0;
      roi_ovf <= 1'b0;
    end else begin
      wp  <= wp + AW'(nwr);
      rp  <= rp + AW'(pop_ok);
      occ <= occ + nwr - (AW+1)'(pop_ok);
      if (drop) roi_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wen)
      for (int i = 0; i < NW; i++)
        if (cand[i] && (int'(off[i]) < int'(free)))
          mem[wp + AW'(off[i])] <= rec[i];
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));
  assert_write_needs_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (occ > $past(occ)) |-> (out_valid && $past(in_accept, 3)));
  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (rst)
    occ <= FDV);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    roi_ovf |=> roi_ovf);
endmodule

// File: tb/sim_swin_cluster_counter.sv
module sim_swin_cluster_counter;
  localparam int ETA = 8, PHI = 8, EW = 10, NTH = 4, CW = 3, FD = 16;
  localparam int SW = EW + 2, NE = ETA - 1, NP = PHI - 1;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_accept = 1'b0, roi_pop = 1'b0;
  logic [ETA*PHI*EW-1:0] in_grid = '0;
  logic [NTH*SW-1:0]     in_thr  = '0;
  logic                  out_valid, roi_empty, roi_ovf;
  logic [NTH*CW-1:0]     out_count;
  logic [15:0]           out_total;
  logic [17:0]           roi_data;

  swin_cluster_counter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_grid(in_grid), .in_thr(in_thr),
    .in_accept(in_accept), .out_valid(out_valid), .out_count(out_count),
    .out_total(out_total), .roi_pop(roi_pop), .roi_empty(roi_empty),
    .roi_data(roi_data), .roi_ovf(roi_ovf));

  always #4 clk = ~clk;

  int g [ETA][PHI];
  int thr [NTH];
  int e_cnt [2][NTH];
  int e_tot [2];
  int mq [256];
  int mh = 0, mt = 0;
  bit e_ovf = 0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ws(int e, int p);
    if (e < 0 || p < 0 || e >= NE || p >= NP) return 0;
    return g[e][p] + g[e+1][p] + g[e][p+1] + g[e+1][p+1];
  endfunction

  task automatic calc(int slot, bit acc);
    int tot = 0;
    for (int t = 0; t < NTH; t++) e_cnt[slot][t] = 0;
    for (int e = 0; e < ETA; e++)
      for (int p = 0; p < PHI; p++) tot += g[e][p];
    e_tot[slot] = tot;
    for (int e = 0; e < NE; e++)
      for (int p = 0; p < NP; p++) begin
        int s = ws(e, p);
        bit pk = (s > ws(e-1, p)) && (s > ws(e, p-1)) && (s >= ws(e+1, p)) && (s >= ws(e, p+1));
        bit any = 0;
        for (int t = 0; t < NTH; t++)
          if (pk && s > thr[t]) begin e_cnt[slot][t]++; any = 1; end
        if (any && acc) begin
          if (mt - mh < FD) begin mq[mt % 256] = (e << 15) | (p << 12) | s; mt++; end
          else e_ovf = 1;
        end
      end
    for (int t = 0; t < NTH; t++) if (e_cnt[slot][t] > 7) e_cnt[slot][t] = 7;
  endtask

  task automatic drive(bit acc);
    for (int e = 0; e < ETA; e++)
      for (int p = 0; p < PHI; p++) in_grid[(e*PHI+p)*EW +: EW] = EW'(g[e][p]);
    for (int t = 0; t < NTH; t++) in_thr[t*SW +: SW] = SW'(thr[t]);
    in_valid  = 1'b1;
    in_accept = acc;
  endtask

  task automatic fill(int v);
    for (int e = 0; e < ETA; e++) for (int p = 0; p < PHI; p++) g[e][p] = v;
  endtask

  task automatic peaks9();
    fill(0);
    for (int e = 0; e < ETA; e += 3)
      for (int p = 0; p < PHI; p += 3) g[e][p] = 200 + e*10 + p;
  endtask

  task automatic set_thr(int a, int b, int c, int d);
    thr[0] = a; thr[1] = b; thr[2] = c; thr[3] = d;
  endtask

  task automatic check_out(int slot, string req);
    check({req, " out_valid"}, int'(out_valid), 1);
    for (int t = 0; t < NTH; t++)
      check({req, " count"}, int'(out_count[t*CW +: CW]), e_cnt[slot][t]);
    check({req, " total R4"}, int'(out_total), e_tot[slot]);
  endtask

  task automatic one_frame(bit acc, string req);
    @(negedge clk);
    drive(acc);
    calc(0, acc);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_accept = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_out(0, req);
    @(posedge clk);
    @(negedge clk);
    check({req, " R1 single pulse"}, int'(out_valid), 0);
  endtask

  task automatic drain(string req);
    while (mh < mt) begin
      check({req, " R6 not empty"}, int'(roi_empty), 0);
      check({req, " R5 record"}, int'(roi_data), mq[mh % 256]);
      roi_pop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      roi_pop = 1'b0;
      mh++;
    end
    check({req, " R6 empty after drain"}, int'(roi_empty), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_accept = 1'b0; roi_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mh = 0; mt = 0; e_ovf = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 out_valid", int'(out_valid), 0);
    check("R8 counts", int'(out_count), 0);
    check("R8 total", int'(out_total), 0);
    check("R8 empty", int'(roi_empty), 1);
    check("R8 ovf", int'(roi_ovf), 0);
  endtask

  task automatic t_single_peak();
    fill(0); g[3][4] = 100;
    set_thr(10, 50, 150, 300);
    one_frame(1, "R2 single peak");
    check("R2 one object", e_cnt[0][0], 1);
    check("R5 record count", mt - mh, 1);
    check("R5 record value", mq[mh % 256], (2 << 15) | (3 << 12) | 100);
    drain("single peak");
  endtask

  task automatic t_plateau();
    fill(5);
    set_thr(0, 19, 20, 100);
    one_frame(1, "R2 R3 plateau");
    drain("plateau");
  endtask

  task automatic t_saturate_noaccept();
    peaks9();
    set_thr(0, 240, 262, 500);
    one_frame(0, "R3 saturate");
    check("R5 no accept leaves queue empty", int'(roi_empty), 1);
  endtask

  task automatic t_full_scale();
    fill(1023);
    set_thr(4091, 4092, 0, 4095);
    one_frame(1, "R3 R4 full scale");
    drain("full scale");
  endtask

  task automatic t_back2back();
    @(negedge clk);
    peaks9(); set_thr(0, 230, 250, 260);
    drive(1); calc(0, 1);
    @(posedge clk);
    @(negedge clk);
    fill(0); g[6][1] = 400; g[7][1] = 300; set_thr(100, 600, 700, 800);
    drive(0); calc(1, 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_accept = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_out(0, "R1 back-to-back first");
    @(posedge clk);
    @(negedge clk);
    check_out(1, "R1 back-to-back second");
    @(posedge clk);
    @(negedge clk);
    check("R1 b2b pulse ends", int'(out_valid), 0);
    drain("back-to-back");
  endtask

  task automatic t_pop_empty();
    @(negedge clk);
    roi_pop = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    roi_pop = 1'b0;
    check("R9 still empty", int'(roi_empty), 1);
    fill(0); g[1][1] = 77; g[5][5] = 99;
    set_thr(50, 80, 90, 1000);
    one_frame(1, "R9 after empty pops");
    drain("R9 order kept");
  endtask

  task automatic t_overflow();
    do_reset();
    peaks9(); set_thr(0, 1, 2, 3);
    one_frame(1, "R7 first fill");
    check("R7 no ovf yet", int'(roi_ovf), 0);
    one_frame(1, "R7 second fill");
    check("R7 model overflow", int'(e_ovf), 1);
    check("R7 ovf flag", int'(roi_ovf), 1);
    check("R7 stored count", mt - mh, 16);
    drain("R7 overflow");
    check("R7 ovf sticky", int'(roi_ovf), 1);
    do_reset();
    check("R8 ovf cleared", int'(roi_ovf), 0);
  endtask

  initial begin
    t_reset();
    t_single_peak();
    t_plateau();
    t_saturate_noaccept();
    t_full_scale();
    t_back2back();
    t_pop_empty();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule